// File: doc/BRIEF.md
# GPIO Interrupt and Wake Controller

This block holds the control and status word for each of a small set of general-purpose pins. It is parameterized in the number of pins. Each pin's word sets whether the pin drives its pad and at what value. It also reports the current input level and selects how the pin raises events. An event source is chosen by a level/edge selector and a two-bit polarity field. When an event qualifies, it sets a sticky interrupt flag, a sticky wake flag, or both. Software clears these flags by writing 1 to them. Each pin drives a pending line toward a summary block, and a single interrupt output goes high when any pin's interrupt is enabled, unmasked and flagged.

A global word holds a blackout enable and a 12-bit blackout length. While the blackout is enabled, a pin write that changes that pin's 4-bit debounce field opens a window of the programmed number of cycles. During the window no pin can set any status flag, and every pin's interrupt-enable bit reads back as 0. Software can poll that bit to learn when the window has closed.

Registers are written through a one-cycle write strobe with a select. They are read through a combinational read port. Select values 0 to NUM_PINS-1 address the pins, and select NUM_PINS addresses the global word.

Top module: `gpio_intwake_top`

## Requirements
- R1: Pin word layout: bit 0 output enable and bit 1 output value drive pad_oe and pad_out for that pin. Bit 2 always reads the present pin_level. Bits 15:13 and 31:20 read 0. Bits 19:16 hold the debounce field.
- R2: With bit 3 = 0 (edge mode), the polarity field in bits 5:4 selects the event. Code 0 is a rising edge, 1 a falling edge and 2 either edge, each judged against the level of the previous cycle. The event sets the interrupt flag (bit 8) at the next clock edge when bit 6 (enable) is 1.
- R3: With bit 3 = 1 (level mode), polarity 0 sets the flag on every cycle the input is high and polarity 1 on every cycle it is low. Polarity codes 2 and 3 never set a flag in level mode, and code 3 never sets one in edge mode.
- R4: The interrupt flag is set only while the enable bit is 1. The mask bit (bit 7) does not gate setting of the flag.
- R5: Bits 8 and 12 clear only when written with 1, and otherwise hold. When a clear and a new event fall in the same cycle, the flag stays set.
- R6: irq is high exactly when some pin has its interrupt flag, enable bit and mask bit all at 1.
- R7: sleep_state 1, 2 and 3 select wake-enable bit 9, 10 or 11. An event on a pin whose selected wake-enable is 1 sets the wake flag (bit 12). sleep_state 0 never sets it. Setting the wake flag does not require the interrupt enable.
- R8: pending[i] is high whenever pin i has its interrupt flag or its wake flag set, regardless of mask.
- R9: The global word has the length in bits 11:0 and the enable in bit 12. If the enable is set and the length L is nonzero, a pin write whose bits 19:16 differ from the stored value blocks all flag setting for the L cycles after the write. During those cycles bit 6 of every pin word reads 0. With the enable clear, no window opens.
- R10: Synchronous reset clears all configuration, flags, the global word and the blackout counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_sel | input | SEL_W | Word select for writes (NUM_PINS = global) |
| wr_data | input | 32 | Write data |
| rd_sel | input | SEL_W | Word select for the read port |
| rd_data | output | 32 | Combinational read data |
| pin_level | input | NUM_PINS | Debounced input level per pin |
| sleep_state | input | 2 | 0 running, 1/2/3 the three sleep states |
| pad_oe | output | NUM_PINS | Pad output enable per pin |
| pad_out | output | NUM_PINS | Pad output value per pin |
| pending | output | NUM_PINS | Per-pin pending indication to the summary block |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets the cycle where a write-1 clear meets a fresh event. A design where the clear wins would lose the event and drop pending. It drives the either-edge code in level mode and checks that no flag appears; a design that decodes polarity alone would fire there. It opens a three-cycle blackout and raises a pin edge inside it. A design that does not block would flag the pin, and one with an off-by-one count would show the enable bit returning a cycle early or late. It also checks that a masked pin still flags and stays pending while irq stays low.

// File: rtl/gpio_iw_pkg.sv
package gpio_iw_pkg;

    localparam int REG_W = 32;
    localparam int DB_W  = 4;
    localparam int LEN_W = 12;

    // pin word bit positions
    localparam int B_OE  = 0;
    localparam int B_OV  = 1;
    localparam int B_STS = 2;
    localparam int B_LVL = 3;
    localparam int B_ACT = 4;
    localparam int B_IEN = 6;
    localparam int B_MSK = 7;
    localparam int B_IST = 8;
    localparam int B_W0  = 9;
    localparam int B_W3  = 10;
    localparam int B_W45 = 11;
    localparam int B_WST = 12;
    localparam int B_DB  = 16;

    // global word
    localparam int G_EN  = 12;

    typedef enum logic [1:0] {
        ACT_HI   = 2'd0,
        ACT_LO   = 2'd1,
        ACT_BOTH = 2'd2,
        ACT_OFF  = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        SLP_RUN  = 2'd0,
        SLP_S0I3 = 2'd1,
        SLP_S3   = 2'd2,
        SLP_S45  = 2'd3
    } slp_e;

    typedef struct packed {
        logic [DB_W-1:0] db;
        logic            wk_s45;
        logic            wk_s3;
        logic            wk_s0;
        logic            msk;
        logic            ien;
        act_e            act;
        logic            lvl_mode;
        logic            ov;
        logic            oe;
    } pin_cfg_t;

    function automatic pin_cfg_t cfg_from_word(input logic [REG_W-1:0] w);
        pin_cfg_t c;
        c.db       = w[B_DB +: DB_W];
        c.wk_s45   = w[B_W45];
        c.wk_s3    = w[B_W3];
        c.wk_s0    = w[B_W0];
        c.msk      = w[B_MSK];
        c.ien      = w[B_IEN];
        c.act      = act_e'(w[B_ACT +: 2]);
        c.lvl_mode = w[B_LVL];
        c.ov       = w[B_OV];
        c.oe       = w[B_OE];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] word_from_cfg(
        input pin_cfg_t c, input logic ist, input logic wst,
        input logic lvl, input logic hide_ien);
        logic [REG_W-1:0] w;
        w               = '0;
        w[B_OE]         = c.oe;
        w[B_OV]         = c.ov;
        w[B_STS]        = lvl;
        w[B_LVL]        = c.lvl_mode;
        w[B_ACT +: 2]   = c.act;
        w[B_IEN]        = c.ien & ~hide_ien;
        w[B_MSK]        = c.msk;
        w[B_IST]        = ist;
        w[B_W0]         = c.wk_s0;
        w[B_W3]         = c.wk_s3;
        w[B_W45]        = c.wk_s45;
        w[B_WST]        = wst;
        w[B_DB +: DB_W] = c.db;
        return w;
    endfunction

    // qualifying event for the current cycle
    function automatic logic trig_hit(input pin_cfg_t c, input logic cur, input logic prev);
        logic hit;
        hit = 1'b0;
        if (c.lvl_mode) begin
            case (c.act)
                ACT_HI:  hit = cur;
                ACT_LO:  hit = ~cur;
                default: hit = 1'b0;
            endcase
        end else begin
            case (c.act)
                ACT_HI:   hit = cur & ~prev;
                ACT_LO:   hit = ~cur & prev;
                ACT_BOTH: hit = cur ^ prev;
                default:  hit = 1'b0;
            endcase
        end
        return hit;
    endfunction

    function automatic logic wake_armed(input pin_cfg_t c, input slp_e s);
        logic a;
        case (s)
            SLP_S0I3: a = c.wk_s0;
            SLP_S3:   a = c.wk_s3;
            SLP_S45:  a = c.wk_s45;
            default:  a = 1'b0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/gpio_iw_evt.sv
module gpio_iw_evt
    import gpio_iw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_cfg_t cfg,
    input  logic     lvl,
    output logic     hit
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    assign hit = trig_hit(cfg, lvl, prev_q);
endmodule

// File: rtl/gpio_iw_pin.sv
module gpio_iw_pin
    import gpio_iw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             hit,
    input  logic             blocked,
    input  logic [1:0]       sleep,
    output pin_cfg_t         cfg,
    output logic             ist,
    output logic             wst,
    output logic             db_wr
);
    logic ist_set, wst_set, ist_clr, wst_clr;

    assign ist_set = hit & cfg.ien & ~blocked;
    assign wst_set = hit & wake_armed(cfg, slp_e'(sleep)) & ~blocked;
    assign ist_clr = wr & wdata[B_IST];
    assign wst_clr = wr & wdata[B_WST];
    assign db_wr   = wr && (wdata[B_DB +: DB_W] != cfg.db);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            ist <= 1'b0;
            wst <= 1'b0;
        end else begin
            if (wr) cfg <= cfg_from_word(wdata);
            ist <= (ist & ~ist_clr) | ist_set;
            wst <= (wst & ~wst_clr) | wst_set;
        end
    end
endmodule

// File: rtl/gpio_iw_blk.sv
module gpio_iw_blk
    import gpio_iw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_glb,
    input  logic [REG_W-1:0] wdata,
    input  logic             db_wr_any,
    output logic [REG_W-1:0] glb_word,
    output logic [LEN_W-1:0] cnt,
    output logic             start,
    output logic             blocked
);
    logic             en_q;
    logic [LEN_W-1:0] len_q;

    assign start   = en_q && (len_q != '0) && db_wr_any;
    assign blocked = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            len_q <= '0;
            cnt   <= '0;
        end else begin
            if (wr_glb) begin
                en_q  <= wdata[G_EN];
                len_q <= wdata[LEN_W-1:0];
            end
            if (start)        cnt <= len_q;
            else if (blocked) cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        glb_word              = '0;
        glb_word[G_EN]        = en_q;
        glb_word[LEN_W-1:0]   = len_q;
    end
endmodule

// File: rtl/gpio_intwake_top.sv
module gpio_intwake_top
    import gpio_iw_pkg::*;
#(
    parameter int NUM_PINS = 4,
    localparam int SEL_W   = $clog2(NUM_PINS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [REG_W-1:0]    wr_data,
    input  logic [SEL_W-1:0]    rd_sel,
    output logic [REG_W-1:0]    rd_data,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [1:0]          sleep_state,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pending,
    output logic                irq
);
    localparam logic [SEL_W-1:0] GLB_SEL = SEL_W'(NUM_PINS);

    pin_cfg_t            cfg    [NUM_PINS];
    logic [REG_W-1:0]    pin_word [NUM_PINS];
    logic [NUM_PINS-1:0] ist, wst, db_wr, hit, fire;
    logic [REG_W-1:0]    glb_word;
    logic [LEN_W-1:0]    blk_cnt;
    logic                blk_start, blocked;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        gpio_iw_evt u_evt (
            .clk (clk),
            .rst (rst),
            .cfg (cfg[i]),
            .lvl (pin_level[i]),
            .hit (hit[i])
        );

        gpio_iw_pin u_pin (
            .clk     (clk),
            .rst     (rst),
            .wr      (wr_en && (wr_sel == SEL_W'(i))),
            .wdata   (wr_data),
            .hit     (hit[i]),
            .blocked (blocked),
            .sleep   (sleep_state),
            .cfg     (cfg[i]),
            .ist     (ist[i]),
            .wst     (wst[i]),
            .db_wr   (db_wr[i])
        );

        assign pin_word[i] = word_from_cfg(cfg[i], ist[i], wst[i], pin_level[i], blocked);
        assign pad_oe[i]   = cfg[i].oe;
        assign pad_out[i]  = cfg[i].ov;
        assign pending[i]  = ist[i] | wst[i];
        assign fire[i]     = ist[i] & cfg[i].ien & cfg[i].msk;
    end

    gpio_iw_blk u_blk (
        .clk       (clk),
        .rst       (rst),
        .wr_glb    (wr_en && (wr_sel == GLB_SEL)),
        .wdata     (wr_data),
        .db_wr_any (|db_wr),
        .glb_word  (glb_word),
        .cnt       (blk_cnt),
        .start     (blk_start),
        .blocked   (blocked)
    );

    assign irq = |fire;

    always_comb begin
        rd_data = '0;
        if (rd_sel == GLB_SEL) rd_data = glb_word;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (rd_sel == SEL_W'(i)) rd_data = pin_word[i];
        end
    end
endmodule

// File: rtl/gpio_intwake_chk.sv
module gpio_intwake_chk #(
    parameter int NUM_PINS = 4,
    parameter int LEN_W    = 12
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [NUM_PINS-1:0] pending,
    input logic                irq,
    input logic [LEN_W-1:0]    blk_cnt,
    input logic                blk_start
);
    // R6
    irq_has_pending_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (pending != '0));

    // R5
    flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((~pending & $past(pending)) == '0));

    // R9
    blackout_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (blk_cnt != '0 && pending == '0) |=> (pending == '0));

    // R9
    blackout_count_chk: assert property (@(posedge clk) disable iff (rst)
        (blk_cnt != '0 && !blk_start) |=> (blk_cnt == $past(blk_cnt) - LEN_W'(1)));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pending == '0 && !irq && blk_cnt == '0));
endmodule

bind gpio_intwake_top gpio_intwake_chk #(
    .NUM_PINS (NUM_PINS),
    .LEN_W    (gpio_iw_pkg::LEN_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .pending   (pending),
    .irq       (irq),
    .blk_cnt   (blk_cnt),
    .blk_start (blk_start)
);

// File: tb/tb_gpio_intwake_top.sv
module tb_gpio_intwake_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int SW = 3;

    typedef struct packed {
        logic [3:0]  req;
        logic        wr;
        logic [2:0]  sel;
        logic [31:0] wdata;
        logic [3:0]  lvl;
        logic [1:0]  slp;
        logic [2:0]  rsel;
        logic [31:0] exp_rd;
        logic [3:0]  exp_pend;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 40;
    localparam vec_t VECS [NV] = '{
        // R1 output drive bits
        '{4'd1,1'b1,3'd0,32'h00003,4'h0,2'd0,3'd0,32'h00003,4'h0,1'b0},
        // R2 rising edge mode, enable+mask
        '{4'd2,1'b1,3'd0,32'h000C0,4'h0,2'd0,3'd0,32'h000C0,4'h0,1'b0},
        '{4'd2,1'b0,3'd0,32'h0,    4'h1,2'd0,3'd0,32'h001C4,4'h1,1'b1},
        '{4'd5,1'b0,3'd0,32'h0,    4'h1,2'd0,3'd0,32'h001C4,4'h1,1'b1},
        // R5 clear
        '{4'd5,1'b1,3'd0,32'h001C0,4'h1,2'd0,3'd0,32'h000C4,4'h0,1'b0},
        '{4'd2,1'b0,3'd0,32'h0,    4'h0,2'd0,3'd0,32'h000C0,4'h0,1'b0},
        // R2 falling
        '{4'd2,1'b1,3'd0,32'h000D0,4'h0,2'd0,3'd0,32'h000D0,4'h0,1'b0},
        '{4'd2,1'b0,3'd0,32'h0,    4'h1,2'd0,3'd0,32'h000D4,4'h0,1'b0},
        '{4'd2,1'b0,3'd0,32'h0,    4'h0,2'd0,3'd0,32'h001D0,4'h1,1'b1},
        // R6 R8 masked: pending stays, irq low
        '{4'd6,1'b1,3'd0,32'h00050,4'h0,2'd0,3'd0,32'h00150,4'h1,1'b0},
        '{4'd5,1'b1,3'd0,32'h001D0,4'h0,2'd0,3'd0,32'h000D0,4'h0,1'b0},
        // R2 both edges
        '{4'd2,1'b1,3'd0,32'h000E0,4'h0,2'd0,3'd0,32'h000E0,4'h0,1'b0},
        '{4'd2,1'b0,3'd0,32'h0,    4'h1,2'd0,3'd0,32'h001E4,4'h1,1'b1},
        // R5 clear in same cycle as falling event: stays set
        '{4'd5,1'b1,3'd0,32'h001E0,4'h0,2'd0,3'd0,32'h001E0,4'h1,1'b1},
        '{4'd5,1'b1,3'd0,32'h001E0,4'h0,2'd0,3'd0,32'h000E0,4'h0,1'b0},
        // R3 level high
        '{4'd3,1'b1,3'd0,32'h000C8,4'h0,2'd0,3'd0,32'h000C8,4'h0,1'b0},
        '{4'd3,1'b0,3'd0,32'h0,    4'h1,2'd0,3'd0,32'h001CC,4'h1,1'b1},
        '{4'd3,1'b1,3'd0,32'h001C8,4'h1,2'd0,3'd0,32'h001CC,4'h1,1'b1},
        '{4'd5,1'b0,3'd0,32'h0,    4'h0,2'd0,3'd0,32'h001C8,4'h1,1'b1},
        '{4'd5,1'b1,3'd0,32'h001C8,4'h0,2'd0,3'd0,32'h000C8,4'h0,1'b0},
        // R3 both code in level mode never fires
        '{4'd3,1'b1,3'd0,32'h000E8,4'h0,2'd0,3'd0,32'h000E8,4'h0,1'b0},
        '{4'd3,1'b0,3'd0,32'h0,    4'h1,2'd0,3'd0,32'h000EC,4'h0,1'b0},
        '{4'd3,1'b0,3'd0,32'h0,    4'h0,2'd0,3'd0,32'h000E8,4'h0,1'b0},
        // R4 enable off: no flag
        '{4'd4,1'b1,3'd0,32'h00080,4'h0,2'd0,3'd0,32'h00080,4'h0,1'b0},
        '{4'd4,1'b0,3'd0,32'h0,    4'h1,2'd0,3'd0,32'h00084,4'h0,1'b0},
        // R7 wake in S3 on pin 1
        '{4'd7,1'b1,3'd1,32'h00400,4'h0,2'd2,3'd1,32'h00400,4'h0,1'b0},
        '{4'd7,1'b0,3'd1,32'h0,    4'h2,2'd2,3'd1,32'h01404,4'h2,1'b0},
        '{4'd7,1'b1,3'd1,32'h01400,4'h2,2'd2,3'd1,32'h00404,4'h0,1'b0},
        '{4'd7,1'b0,3'd1,32'h0,    4'h0,2'd2,3'd1,32'h00400,4'h0,1'b0},
        '{4'd7,1'b0,3'd1,32'h0,    4'h2,2'd1,3'd1,32'h00404,4'h0,1'b0},
        // R9 blackout enable, length 3
        '{4'd9,1'b1,3'd4,32'h01003,4'h0,2'd0,3'd4,32'h01003,4'h0,1'b0},
        '{4'd9,1'b1,3'd2,32'h000C0,4'h0,2'd0,3'd2,32'h000C0,4'h0,1'b0},
        '{4'd9,1'b1,3'd2,32'h500C0,4'h0,2'd0,3'd2,32'h50080,4'h0,1'b0},
        '{4'd9,1'b0,3'd2,32'h0,    4'h4,2'd0,3'd2,32'h50084,4'h0,1'b0},
        '{4'd9,1'b0,3'd2,32'h0,    4'h4,2'd0,3'd2,32'h50084,4'h0,1'b0},
        '{4'd9,1'b0,3'd2,32'h0,    4'h4,2'd0,3'd2,32'h500C4,4'h0,1'b0},
        '{4'd9,1'b0,3'd2,32'h0,    4'h0,2'd0,3'd2,32'h500C0,4'h0,1'b0},
        '{4'd9,1'b0,3'd2,32'h0,    4'h4,2'd0,3'd2,32'h501C4,4'h4,1'b1},
        // R9 blackout disabled: no window
        '{4'd9,1'b1,3'd4,32'h00003,4'h4,2'd0,3'd4,32'h00003,4'h4,1'b1},
        '{4'd9,1'b1,3'd2,32'h601C0,4'h4,2'd0,3'd2,32'h600C4,4'h0,1'b0}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic [SW-1:0] wr_sel;
    logic [31:0]   wr_data;
    logic [SW-1:0] rd_sel;
    logic [31:0]   rd_data;
    logic [NP-1:0] pin_level;
    logic [1:0]    sleep_state;
    logic [NP-1:0] pad_oe, pad_out, pending;
    logic          irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_intwake_top #(.NUM_PINS(NP)) dut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .rd_sel      (rd_sel),
        .rd_data     (rd_data),
        .pin_level   (pin_level),
        .sleep_state (sleep_state),
        .pad_oe      (pad_oe),
        .pad_out     (pad_out),
        .pending     (pending),
        .irq         (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic [SW-1:0] s, input logic [31:0] d,
                        input logic [NP-1:0] l, input logic [1:0] sl, input logic [SW-1:0] rs);
        @(negedge clk);
        wr_en = w; wr_sel = s; wr_data = d;
        pin_level = l; sleep_state = sl; rd_sel = rs;
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        rd_sel = '0; pin_level = '0; sleep_state = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R10 reset state
        chk("R10 rd", rd_data, 32'h0);
        chk("R10 pend", {28'h0, pending}, 32'h0);
        chk("R10 irq", {31'h0, irq}, 32'h0);
        chk("R10 pad", {24'h0, pad_oe, pad_out}, 32'h0);

        for (int k = 0; k < NV; k++) begin
            step(VECS[k].wr, VECS[k].sel, VECS[k].wdata, VECS[k].lvl, VECS[k].slp, VECS[k].rsel);
            chk($sformatf("R%0d vec%0d rd", VECS[k].req, k), rd_data, VECS[k].exp_rd);
            chk($sformatf("R%0d vec%0d pend", VECS[k].req, k), {28'h0, pending}, {28'h0, VECS[k].exp_pend});
            chk($sformatf("R%0d vec%0d irq", VECS[k].req, k), {31'h0, irq}, {31'h0, VECS[k].exp_irq});
        end

        // R1 reserved bits and pad drive
        step(1'b1, 3'd3, 32'hFFFF_FFFF, 4'h0, 2'd0, 3'd3);
        chk("R1 reserved", rd_data, 32'h000F_0EFB);
        step(1'b1, 3'd0, 32'h0000_0002, 4'h0, 2'd0, 3'd0);
        chk("R1 pad_oe", {28'h0, pad_oe}, 32'h8);
        chk("R1 pad_out", {28'h0, pad_out}, 32'h9);
        // R3 code 3 in level mode on pin3, input high
        step(1'b0, 3'd0, 32'h0, 4'h8, 2'd0, 3'd3);
        chk("R3 off code", {28'h0, pending}, 32'h0);
        chk("R1 pin status", rd_data, 32'h000F_0EFF);

        // R10 mid-run reset
        @(negedge clk);
        wr_en = 1'b0; rst = 1'b1; pin_level = '0;
        @(posedge clk);
        #1;
        rst = 1'b0;
        chk("R10 rerst rd", rd_data, 32'h0);
        chk("R10 rerst pad", {28'h0, pad_oe}, 32'h0);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule